// File: doc/BRIEF.md
# Directory-Coherent Cache Line Controller

This block is the cache-side half of a directory coherence scheme for one processor. It keeps a small direct-mapped cache. Each line holds a multi-word block, a tag and a coherence state: Invalid, Shared (readable) or Exclusive (readable and writable, and always treated as dirty). The CPU presents a word request and holds it until `cpu_done` pulses. A hit completes locally. A miss sends a request message to the home directory and stalls the CPU until the directory returns the block.

The directory also sends unsolicited messages to this controller: invalidate, fetch, and fetch-with-invalidate. These are handled in the cycle they arrive. Any write-back they cause goes out on the same outbound message port that carries miss requests. Messages on both sides are single-cycle pulses with no back-pressure. Both sides are assumed to deliver messages in the order they were issued.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_done` and `msg_out_valid` are low, and the first access to any address misses.
- R2: A CPU read that finds no valid line with a matching tag sends a read-miss message (type 0) carrying the block address (word address without the offset bits). When the data reply arrives (inbound type 3), the line becomes Shared and `cpu_rdata` returns the requested word of the supplied block.
- R3: A CPU write to a line that is Invalid, or Shared with the same tag, sends a write-miss message (type 1). When the reply arrives, the line becomes Exclusive, holding the reply block with the written word merged in.
- R4: Read hits in Shared or Exclusive and write hits in Exclusive send no message. `cpu_done` rises in the cycle after the request is accepted.
- R5: A write hit replaces only the addressed word of an Exclusive line. Later reads and write-backs show the merged block. On any write completion `cpu_rdata` echoes the written word.
- R6: An invalidate (inbound type 0) makes a matching Shared line Invalid and produces no outbound message. An invalidate on an Exclusive line has no effect.
- R7: A fetch (inbound type 1) on a matching Exclusive line sends a write-back (type 2) of the block in the next cycle and leaves the line Shared.
- R8: A fetch-with-invalidate (inbound type 2) on a matching Exclusive line sends a write-back of the block in the next cycle and leaves the line Invalid.
- R9: A miss whose index holds an Exclusive line with another tag first sends a write-back of that line. The miss message follows in the next cycle. A Shared line with another tag is dropped without a message.
- R10: During a miss the CPU is stalled. `cpu_done` stays low until the reply is accepted, then pulses for exactly one cycle, in the cycle after the reply.
- R11: An inbound directory message is always handled in the cycle it arrives, including while a miss is outstanding. CPU-side progress (a lookup, or emitting a pending miss) waits that cycle.
- R12: Directory messages whose tag does not match the valid line at their index have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request present; held until `cpu_done` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address: tag, index, offset from MSB down |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, or echoed write word, valid with `cpu_done` |
| dir_in_valid | input | 1 | Inbound directory message strobe |
| dir_in_type | input | 2 | 0 invalidate, 1 fetch, 2 fetch-with-invalidate, 3 data reply |
| dir_in_addr | input | BADDR_W | Block address of the message |
| dir_in_data | input | BLK_W | Block data for a reply |
| msg_out_valid | output | 1 | Outbound message strobe |
| msg_out_type | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| msg_out_addr | output | BADDR_W | Block address |
| msg_out_data | output | BLK_W | Block data for a write-back |

## Verification
A wrong line state shows up at the ports at the next access to that line. A stale Shared line answers a read that should miss, and a line wrongly left Exclusive answers a fetch with a write-back that should not exist, one cycle after the message. A lost merge or a wrong eviction order shows up in the data or ordering of write-backs. The bench therefore runs a behavioural model of every line and compares `cpu_done`, `cpu_rdata` and each outbound message on every cycle. Directory messages are injected during outstanding misses and on the eviction cycle.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LN_INV = 2'd0, LN_SHR = 2'd1, LN_EXC = 2'd2} line_st_e;
  typedef enum logic [1:0] {OM_RDMISS = 2'd0, OM_WRMISS = 2'd1, OM_WBACK = 2'd2} out_msg_e;
  typedef enum logic [1:0] {IM_INVAL = 2'd0, IM_FETCH = 2'd1, IM_FETCHINV = 2'd2, IM_REPLY = 2'd3} in_msg_e;
  typedef enum logic [1:0] {CS_IDLE = 2'd0, CS_EVICT = 2'd1, CS_WAIT = 2'd2, CS_RESP = 2'd3} ctl_st_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TAG_W = 6,
  parameter int BLK_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output line_st_e         a_state,
  output logic [TAG_W-1:0] a_tag,
  output logic [BLK_W-1:0] a_data,
  input  logic [IDX_W-1:0] b_idx,
  output line_st_e         b_state,
  output logic [TAG_W-1:0] b_tag,
  output logic [BLK_W-1:0] b_data,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  line_st_e         w_state,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [BLK_W-1:0] w_data
);
  line_st_e         st_q   [LINES];
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [BLK_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = we && (w_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q[g] <= LN_INV;
      else if (sel) st_q[g] <= w_state;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[g]  <= w_tag;
        data_q[g] <= w_data;
      end
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = data_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = data_q[b_idx];
endmodule

// File: rtl/coh_ctrl_fsm.sv
module coh_ctrl_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int WORDS  = 4,
  parameter int LINES  = 4,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int BADDR_W = ADDR_W - OFF_W,
  localparam int BLK_W   = WORDS * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  input  logic               cpu_req_write,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  output logic               cpu_done,
  output logic [DATA_W-1:0]  cpu_rdata,
  input  logic               dir_in_valid,
  input  logic [1:0]         dir_in_type,
  input  logic [BADDR_W-1:0] dir_in_addr,
  input  logic [BLK_W-1:0]   dir_in_data,
  output logic               msg_out_valid,
  output logic [1:0]         msg_out_type,
  output logic [BADDR_W-1:0] msg_out_addr,
  output logic [BLK_W-1:0]   msg_out_data,
  output logic [IDX_W-1:0]   a_idx,
  input  line_st_e           a_state,
  input  logic [TAG_W-1:0]   a_tag,
  input  logic [BLK_W-1:0]   a_data,
  output logic [IDX_W-1:0]   b_idx,
  input  line_st_e           b_state,
  input  logic [TAG_W-1:0]   b_tag,
  input  logic [BLK_W-1:0]   b_data,
  output logic               we,
  output logic [IDX_W-1:0]   w_idx,
  output line_st_e           w_state,
  output logic [TAG_W-1:0]   w_tag,
  output logic [BLK_W-1:0]   w_data,
  output logic               in_wait
);
  function automatic logic [BLK_W-1:0] merge_word(logic [BLK_W-1:0] base,
                                                  logic [OFF_W-1:0] off,
                                                  logic [DATA_W-1:0] wd);
    logic [BLK_W-1:0] r;
    r = base;
    r[int'(off)*DATA_W +: DATA_W] = wd;
    return r;
  endfunction

  ctl_st_e fsm_q, fsm_d;
  logic done_q, done_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic mo_valid_q, mo_valid_d;
  out_msg_e mo_type_q, mo_type_d;
  logic [BADDR_W-1:0] mo_addr_q, mo_addr_d;
  logic [BLK_W-1:0] mo_data_q, mo_data_d;

  logic [TAG_W-1:0] cpu_tag, dir_tag;
  logic [OFF_W-1:0] cpu_off;
  in_msg_e dtype;
  logic coh_msg, reply_msg, dir_match, cpu_present, cpu_hit;
  out_msg_e miss_type;

  assign cpu_off   = cpu_req_addr[OFF_W-1:0];
  assign a_idx     = cpu_req_addr[OFF_W +: IDX_W];
  assign cpu_tag   = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign b_idx     = dir_in_addr[IDX_W-1:0];
  assign dir_tag   = dir_in_addr[BADDR_W-1 -: TAG_W];
  assign dtype     = in_msg_e'(dir_in_type);
  assign coh_msg   = dir_in_valid && (dtype != IM_REPLY);
  assign reply_msg = dir_in_valid && (dtype == IM_REPLY);
  assign dir_match = (b_state != LN_INV) && (b_tag == dir_tag);
  assign cpu_present = (a_state != LN_INV) && (a_tag == cpu_tag);
  assign cpu_hit   = cpu_present && (!cpu_req_write || a_state == LN_EXC);
  assign miss_type = cpu_req_write ? OM_WRMISS : OM_RDMISS;

  always_comb begin
    fsm_d      = (fsm_q == CS_RESP) ? CS_IDLE : fsm_q;
    done_d     = 1'b0;
    rdata_d    = rdata_q;
    mo_valid_d = 1'b0;
    mo_type_d  = mo_type_q;
    mo_addr_d  = mo_addr_q;
    mo_data_d  = mo_data_q;
    we         = 1'b0;
    w_idx      = a_idx;
    w_state    = a_state;
    w_tag      = cpu_tag;
    w_data     = a_data;
    if (coh_msg) begin
      w_idx  = b_idx;
      w_tag  = b_tag;
      w_data = b_data;
      if (dir_match && dtype == IM_INVAL && b_state == LN_SHR) begin
        we      = 1'b1;
        w_state = LN_INV;
      end else if (dir_match && dtype != IM_INVAL && b_state == LN_EXC) begin
        we         = 1'b1;
        w_state    = (dtype == IM_FETCH) ? LN_SHR : LN_INV;
        mo_valid_d = 1'b1;
        mo_type_d  = OM_WBACK;
        mo_addr_d  = dir_in_addr;
        mo_data_d  = b_data;
      end
    end else begin
      case (fsm_q)
        CS_IDLE: if (cpu_req_valid) begin
          if (cpu_hit) begin
            done_d = 1'b1;
            fsm_d  = CS_RESP;
            if (cpu_req_write) begin
              we      = 1'b1;
              w_data  = merge_word(a_data, cpu_off, cpu_req_wdata);
              rdata_d = cpu_req_wdata;
            end else begin
              rdata_d = a_data[int'(cpu_off)*DATA_W +: DATA_W];
            end
          end else if (a_state == LN_EXC) begin
            we         = 1'b1;
            w_state    = LN_INV;
            w_tag      = a_tag;
            mo_valid_d = 1'b1;
            mo_type_d  = OM_WBACK;
            mo_addr_d  = {a_tag, a_idx};
            mo_data_d  = a_data;
            fsm_d      = CS_EVICT;
          end else begin
            mo_valid_d = 1'b1;
            mo_type_d  = miss_type;
            mo_addr_d  = cpu_req_addr[ADDR_W-1:OFF_W];
            fsm_d      = CS_WAIT;
          end
        end
        CS_EVICT: begin
          mo_valid_d = 1'b1;
          mo_type_d  = miss_type;
          mo_addr_d  = cpu_req_addr[ADDR_W-1:OFF_W];
          fsm_d      = CS_WAIT;
        end
        CS_WAIT: if (reply_msg) begin
          we      = 1'b1;
          w_state = cpu_req_write ? LN_EXC : LN_SHR;
          w_data  = cpu_req_write ? merge_word(dir_in_data, cpu_off, cpu_req_wdata) : dir_in_data;
          rdata_d = cpu_req_write ? cpu_req_wdata : dir_in_data[int'(cpu_off)*DATA_W +: DATA_W];
          done_d  = 1'b1;
          fsm_d   = CS_RESP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q      <= CS_IDLE;
      done_q     <= 1'b0;
      mo_valid_q <= 1'b0;
    end else begin
      fsm_q      <= fsm_d;
      done_q     <= done_d;
      mo_valid_q <= mo_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (done_d) rdata_q <= rdata_d;
    if (mo_valid_d) begin
      mo_type_q <= mo_type_d;
      mo_addr_q <= mo_addr_d;
      mo_data_q <= mo_data_d;
    end
  end

  assign cpu_done      = done_q;
  assign cpu_rdata     = rdata_q;
  assign msg_out_valid = mo_valid_q;
  assign msg_out_type  = mo_type_q;
  assign msg_out_addr  = mo_addr_q;
  assign msg_out_data  = mo_data_q;
  assign in_wait       = (fsm_q == CS_WAIT);
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int WORDS  = 4,
  parameter int LINES  = 4,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int BADDR_W = ADDR_W - OFF_W,
  localparam int BLK_W   = WORDS * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  input  logic               cpu_req_write,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  output logic               cpu_done,
  output logic [DATA_W-1:0]  cpu_rdata,
  input  logic               dir_in_valid,
  input  logic [1:0]         dir_in_type,
  input  logic [BADDR_W-1:0] dir_in_addr,
  input  logic [BLK_W-1:0]   dir_in_data,
  output logic               msg_out_valid,
  output logic [1:0]         msg_out_type,
  output logic [BADDR_W-1:0] msg_out_addr,
  output logic [BLK_W-1:0]   msg_out_data
);
  logic [IDX_W-1:0] a_idx, b_idx, w_idx;
  line_st_e a_state, b_state, w_state;
  logic [TAG_W-1:0] a_tag, b_tag, w_tag;
  logic [BLK_W-1:0] a_data, b_data, w_data;
  logic we, wait_st;

  coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .we(we), .w_idx(w_idx), .w_state(w_state), .w_tag(w_tag), .w_data(w_data)
  );

  coh_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .dir_in_valid(dir_in_valid), .dir_in_type(dir_in_type),
    .dir_in_addr(dir_in_addr), .dir_in_data(dir_in_data),
    .msg_out_valid(msg_out_valid), .msg_out_type(msg_out_type),
    .msg_out_addr(msg_out_addr), .msg_out_data(msg_out_data),
    .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .we(we), .w_idx(w_idx), .w_state(w_state), .w_tag(w_tag), .w_data(w_data),
    .in_wait(wait_st)
  );
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dir_in_valid,
  input logic [1:0] dir_in_type,
  input logic       cpu_done,
  input logic       msg_out_valid,
  input logic [1:0] msg_out_type,
  input logic       in_wait
);
  logic coh;
  assign coh = dir_in_valid && (dir_in_type != 2'd3);

  AST_MSG_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    msg_out_valid |-> (msg_out_type != 2'd3)); // R2

  AST_DONE_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !msg_out_valid); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R10

  AST_WAIT_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !cpu_done); // R10

  AST_REPLY_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && dir_in_valid && dir_in_type == 2'd3) |=> cpu_done); // R10

  AST_EVICT_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_out_valid && msg_out_type == 2'd2 && !$past(coh) && !coh)
      |=> (msg_out_valid && msg_out_type != 2'd2)); // R9
endmodule

bind coh_line_ctrl coh_line_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_in_valid(dir_in_valid), .dir_in_type(dir_in_type),
  .cpu_done(cpu_done), .msg_out_valid(msg_out_valid), .msg_out_type(msg_out_type),
  .in_wait(wait_st)
);

// File: tb/coh_line_ctrl_tb.sv
module coh_line_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ADDR_W = 10, DATA_W = 8, WORDS = 4, LINES = 4;
  localparam int OFF_W = 2, IDX_W = 2, TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int BADDR_W = ADDR_W - OFF_W, BLK_W = WORDS * DATA_W;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req_valid, cpu_req_write;
  logic [ADDR_W-1:0] cpu_req_addr;
  logic [DATA_W-1:0] cpu_req_wdata;
  logic cpu_done;
  logic [DATA_W-1:0] cpu_rdata;
  logic dir_in_valid;
  logic [1:0] dir_in_type;
  logic [BADDR_W-1:0] dir_in_addr;
  logic [BLK_W-1:0] dir_in_data;
  logic msg_out_valid;
  logic [1:0] msg_out_type;
  logic [BADDR_W-1:0] msg_out_addr;
  logic [BLK_W-1:0] msg_out_data;

  always #2.5 clk = ~clk;

  coh_line_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES)) dut_i (.*);

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  logic [1:0] seen[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(int t, int i, int o);
    return ADDR_W'(t * LINES * WORDS + i * WORDS + o);
  endfunction

  function automatic logic [BLK_W-1:0] blk_of(logic [BADDR_W-1:0] ba);
    logic [BLK_W-1:0] b;
    for (int k = 0; k < WORDS; k++) b[k*DATA_W +: DATA_W] = DATA_W'(int'(ba) * 7 + k * 29 + 3);
    return b;
  endfunction

  function automatic logic [DATA_W-1:0] word_of(logic [ADDR_W-1:0] a);
    logic [BLK_W-1:0] b;
    b = blk_of(a[ADDR_W-1:OFF_W]);
    return b[int'(a[OFF_W-1:0])*DATA_W +: DATA_W];
  endfunction

  // Behavioural reference: per-line state, tag and data; 0 idle, 1 evict, 2 wait, 3 respond
  int m_st[LINES];
  int m_tag[LINES];
  logic [BLK_W-1:0] m_data[LINES];
  int m_fsm;
  logic e_done, e_mov;
  logic [DATA_W-1:0] e_rdata;
  logic [1:0] e_mot;
  logic [BADDR_W-1:0] e_moa;
  logic [BLK_W-1:0] e_mod;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) m_st[i] = 0;
      m_fsm = 0; e_done = 0; e_mov = 0;
    end else begin
      int nxt, ci, ct, co, di, dt;
      bit wr;
      e_done = 0; e_mov = 0;
      nxt = (m_fsm == 3) ? 0 : m_fsm;
      wr = cpu_req_write;
      ci = (int'(cpu_req_addr) / WORDS) % LINES;
      ct = int'(cpu_req_addr) / (WORDS * LINES);
      co = int'(cpu_req_addr) % WORDS;
      if (dir_in_valid && dir_in_type != 2'd3) begin
        di = int'(dir_in_addr) % LINES;
        dt = int'(dir_in_addr) / LINES;
        if (m_st[di] != 0 && m_tag[di] == dt) begin
          if (dir_in_type == 2'd0 && m_st[di] == 1) m_st[di] = 0;
          else if (dir_in_type != 2'd0 && m_st[di] == 2) begin
            e_mov = 1; e_mot = 2; e_moa = dir_in_addr; e_mod = m_data[di];
            m_st[di] = (dir_in_type == 2'd1) ? 1 : 0;
          end
        end
      end else if (m_fsm == 0 && cpu_req_valid) begin
        if (m_st[ci] != 0 && m_tag[ci] == ct && (!wr || m_st[ci] == 2)) begin
          e_done = 1; nxt = 3;
          if (wr) begin m_data[ci][co*DATA_W +: DATA_W] = cpu_req_wdata; e_rdata = cpu_req_wdata; end
          else e_rdata = m_data[ci][co*DATA_W +: DATA_W];
        end else if (m_st[ci] == 2) begin
          e_mov = 1; e_mot = 2; e_moa = BADDR_W'(m_tag[ci] * LINES + ci); e_mod = m_data[ci];
          m_st[ci] = 0; nxt = 1;
        end else begin
          e_mov = 1; e_mot = wr ? 2'd1 : 2'd0; e_moa = cpu_req_addr[ADDR_W-1:OFF_W]; nxt = 2;
        end
      end else if (m_fsm == 1) begin
        e_mov = 1; e_mot = wr ? 2'd1 : 2'd0; e_moa = cpu_req_addr[ADDR_W-1:OFF_W]; nxt = 2;
      end else if (m_fsm == 2 && dir_in_valid && dir_in_type == 2'd3) begin
        m_tag[ci] = ct; m_data[ci] = dir_in_data;
        m_st[ci] = wr ? 2 : 1;
        e_rdata = m_data[ci][co*DATA_W +: DATA_W];
        if (wr) begin m_data[ci][co*DATA_W +: DATA_W] = cpu_req_wdata; e_rdata = cpu_req_wdata; end
        e_done = 1; nxt = 3;
      end
      m_fsm = nxt;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(cpu_done === e_done, {cur_req, " done"}, cpu_done, e_done);
    if (e_done) chk(cpu_rdata === e_rdata, {cur_req, " rdata"}, cpu_rdata, e_rdata);
    chk(msg_out_valid === e_mov, {cur_req, " msg valid"}, msg_out_valid, e_mov);
    if (e_mov) begin
      chk(msg_out_type === e_mot, {cur_req, " msg type"}, msg_out_type, e_mot);
      chk(msg_out_addr === e_moa, {cur_req, " msg addr"}, msg_out_addr, e_moa);
      chk(msg_out_data === e_mod || e_mot != 2'd2, {cur_req, " msg data"}, msg_out_data, e_mod);
    end
  end

  task automatic cpu_access(input bit wr, input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd,
                            input int dly, input int inj_type, input logic [BADDR_W-1:0] inj_addr,
                            output logic [DATA_W-1:0] rd, output int lat);
    int cnt = -1, it = 0, miss_it = -1, nmsg = 0;
    seen.delete();
    rd = '0; lat = -1;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = addr; cpu_req_wdata = wd;
    forever begin
      @(negedge clk);
      it++;
      dir_in_valid = 1'b0;
      if (cpu_done) begin
        rd = cpu_rdata;
        if (miss_it >= 0) lat = it - miss_it;
        break;
      end
      if (msg_out_valid) begin
        seen.push_back(msg_out_type);
        nmsg++;
        if (msg_out_type != 2'd2) begin cnt = dly; miss_it = it; end
        if (nmsg == 1 && inj_type >= 0) begin
          dir_in_valid = 1'b1; dir_in_type = 2'(inj_type); dir_in_addr = inj_addr;
        end
      end
      if (cnt == 0) begin
        dir_in_valid = 1'b1; dir_in_type = 2'd3;
        dir_in_addr = addr[ADDR_W-1:OFF_W]; dir_in_data = blk_of(addr[ADDR_W-1:OFF_W]);
        cnt = -1;
      end else if (cnt > 0) cnt--;
      if (it > 300) begin chk(1'b0, {cur_req, " access timeout"}, it, 0); break; end
    end
    cpu_req_valid = 1'b0;
  endtask

  task automatic dir_msg(input int typ, input logic [BADDR_W-1:0] ba);
    seen.delete();
    @(negedge clk);
    dir_in_valid = 1'b1; dir_in_type = 2'(typ); dir_in_addr = ba;
    @(negedge clk);
    dir_in_valid = 1'b0;
    if (msg_out_valid) seen.push_back(msg_out_type);
  endtask

  function automatic logic [BADDR_W-1:0] ba_of(int t, int i);
    return BADDR_W'(t * LINES + i);
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] rd;
    logic [BLK_W-1:0] exp_blk;
    int lat;
    rst_n = 1'b0; cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = '0; cpu_req_wdata = '0;
    dir_in_valid = 0; dir_in_type = '0; dir_in_addr = '0; dir_in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk(!cpu_done && !msg_out_valid, "R1 quiet after reset", {cpu_done, msg_out_valid}, 0);

    cur_req = "R2";
    cpu_access(0, mk(1, 0, 1), 0, 0, -1, '0, rd, lat);
    chk(seen.size() == 1 && seen[0] == 2'd0, "R1 R2 first read sends read miss", seen.size(), 1);
    chk(rd == word_of(mk(1, 0, 1)), "R2 read miss data", rd, word_of(mk(1, 0, 1)));

    cur_req = "R4";
    cpu_access(0, mk(1, 0, 2), 0, 0, -1, '0, rd, lat);
    chk(seen.size() == 0, "R4 shared read hit silent", seen.size(), 0);
    chk(rd == word_of(mk(1, 0, 2)), "R4 shared read hit data", rd, word_of(mk(1, 0, 2)));

    cur_req = "R3";
    cpu_access(1, mk(1, 0, 3), 8'hA5, 0, -1, '0, rd, lat);
    chk(seen.size() == 1 && seen[0] == 2'd1, "R3 write on shared sends write miss", seen.size(), 1);

    cur_req = "R5";
    cpu_access(1, mk(1, 0, 0), 8'h3C, 0, -1, '0, rd, lat);
    chk(seen.size() == 0, "R4 R5 exclusive write hit silent", seen.size(), 0);
    chk(rd == 8'h3C, "R5 write echo", rd, 8'h3C);
    cpu_access(0, mk(1, 0, 3), 0, 0, -1, '0, rd, lat);
    chk(rd == 8'hA5, "R3 merged word after write miss", rd, 8'hA5);
    cpu_access(0, mk(1, 0, 0), 0, 0, -1, '0, rd, lat);
    chk(rd == 8'h3C, "R5 merged word after write hit", rd, 8'h3C);

    cur_req = "R7";
    exp_blk = blk_of(ba_of(1, 0));
    exp_blk[3*DATA_W +: DATA_W] = 8'hA5;
    exp_blk[0 +: DATA_W] = 8'h3C;
    seen.delete();
    @(negedge clk);
    dir_in_valid = 1; dir_in_type = 2'd1; dir_in_addr = ba_of(1, 0);
    @(negedge clk);
    dir_in_valid = 0;
    chk(msg_out_valid && msg_out_type == 2'd2, "R7 fetch gives write-back", msg_out_type, 2);
    chk(msg_out_data == exp_blk, "R5 R7 write-back carries merged block", msg_out_data, exp_blk);
    cpu_access(0, mk(1, 0, 1), 0, 0, -1, '0, rd, lat);
    chk(seen.size() == 0, "R7 line shared after fetch, read hits", seen.size(), 0);
    cpu_access(1, mk(1, 0, 1), 8'h11, 0, -1, '0, rd, lat);
    chk(seen.size() == 1 && seen[0] == 2'd1, "R7 write after fetch misses", seen.size(), 1);

    cur_req = "R8";
    dir_msg(2, ba_of(1, 0));
    chk(seen.size() == 1 && seen[0] == 2'd2, "R8 fetch-inv gives write-back", seen.size(), 1);
    cpu_access(0, mk(1, 0, 1), 0, 0, -1, '0, rd, lat);
    chk(seen.size() == 1 && seen[0] == 2'd0, "R8 line invalid after fetch-inv", seen.size(), 1);

    cur_req = "R6";
    cpu_access(0, mk(2, 1, 0), 0, 0, -1, '0, rd, lat);
    dir_msg(0, ba_of(2, 1));
    chk(seen.size() == 0, "R6 invalidate silent", seen.size(), 0);
    cpu_access(0, mk(2, 1, 0), 0, 0, -1, '0, rd, lat);
    chk(seen.size() == 1 && seen[0] == 2'd0, "R6 read misses after invalidate", seen.size(), 1);
    cpu_access(1, mk(3, 2, 0), 8'h77, 0, -1, '0, rd, lat);
    dir_msg(0, ba_of(3, 2));
    cpu_access(0, mk(3, 2, 0), 0, 0, -1, '0, rd, lat);
    chk(seen.size() == 0 && rd == 8'h77, "R6 invalidate ignored on exclusive", rd, 8'h77);

    cur_req = "R12";
    dir_msg(1, ba_of(5, 2));
    chk(seen.size() == 0, "R12 fetch with wrong tag ignored", seen.size(), 0);
    cpu_access(1, mk(3, 2, 1), 8'h66, 0, -1, '0, rd, lat);
    chk(seen.size() == 0, "R12 line still exclusive", seen.size(), 0);

    cur_req = "R9";
    cpu_access(0, mk(4, 2, 0), 0, 0, -1, '0, rd, lat);
    chk(seen.size() == 2 && seen[0] == 2'd2 && seen[1] == 2'd0, "R9 dirty eviction write-back then miss",
        seen.size(), 2);
    cpu_access(0, mk(6, 1, 0), 0, 0, -1, '0, rd, lat);
    chk(seen.size() == 1 && seen[0] == 2'd0, "R9 shared eviction silent", seen.size(), 1);

    cur_req = "R10";
    cpu_access(0, mk(5, 0, 2), 0, 5, -1, '0, rd, lat);
    chk(lat == 6, "R10 stall until reply", lat, 6);
    chk(rd == word_of(mk(5, 0, 2)), "R10 data after stall", rd, word_of(mk(5, 0, 2)));

    cur_req = "R11";
    cpu_access(1, mk(7, 3, 1), 8'h42, 0, -1, '0, rd, lat);
    cpu_access(0, mk(8, 0, 0), 0, 3, 1, ba_of(7, 3), rd, lat);
    chk(seen.size() == 2 && seen[1] == 2'd2, "R11 fetch served during outstanding miss", seen.size(), 2);
    chk(rd == word_of(mk(8, 0, 0)), "R11 miss completes after fetch", rd, word_of(mk(8, 0, 0)));
    cpu_access(1, mk(7, 3, 2), 8'h24, 0, -1, '0, rd, lat);
    cpu_access(1, mk(6, 1, 0), 8'h99, 0, -1, '0, rd, lat);
    cpu_access(0, mk(9, 3, 0), 0, 0, 1, ba_of(6, 1), rd, lat);
    chk(seen.size() == 3 && seen[1] == 2'd2 && seen[2] == 2'd0, "R11 miss deferred behind fetch write-back",
        seen.size(), 3);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule